// File: doc/BRIEF.md
# Two-Level Interrupt Flag Aggregator

This block gathers interrupt sources in two tiers. Each peripheral vector owns a register of module flags that hardware event pulses set, and an enable register that picks which of those flags may request the CPU. One shared CPU flag register holds a pending bit for every vector. The pending bit sets whenever an enabled module flag is raised. The CPU's acknowledge of that vector clears it in hardware.

Software clears a module flag by writing a mask that is zero at the flag's bit and one everywhere else. Each such write makes the block look again at the flags of that vector that are still set and enabled. If any remain, the pending bit is raised again, so that a handler which services one source per entry is called again for the rest. Priority between vectors and vector address generation belong to the interrupt controller that consumes the pending outputs.

The register port is a simple one-cycle write strobe with a combinational read. Address 0 is the CPU flag register. Address 1+2v holds the module flags of vector v and address 2+2v holds its enables.

Top module: `intflag_agg`

## Requirements
- R1: After reset every module flag and every enable reads 0, the CPU flag register reads 8'h05 (bits 0 and 2 at 1, all others 0), and every pending output is low.
- R2: An event pulse on a module flag bit sets that bit on the next clock edge. If the bit is enabled at the time of the pulse, the vector's pending bit (CPU register bit 2v+1) sets on the same edge. A pulse on a disabled bit sets the module flag only.
- R3: A write to a module flag register clears each bit written as 0 and leaves each bit written as 1 unchanged. Software can never set a module flag.
- R4: On the edge of a write to a module flag register, the pending bit of that vector is set if any module flag of that vector is still set and enabled after the write. Otherwise the pending bit keeps its value.
- R5: An acknowledge (ack_i high with ack_vec_i = v) clears only pending bit 2v+1 on the next edge. A hardware set of the same bit in the same cycle wins, and the bit stays 1.
- R6: An event pulse and a software clear of the same module flag bit in the same cycle leave the bit set.
- R7: All 8 bits of the CPU flag register are writable and read back as written. Pending output v always equals CPU register bit 2v+1.
- R8: Enable registers read back as written. Reads of addresses with no register behind them (9 to 15) return 0.
- R9: When a write to the CPU flag register coincides with a hardware set or an acknowledge, the written value is applied first, then the acknowledge clear, then the hardware set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 4 | Register address for both read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| evt_i | input | 32 | Event pulses, vector v at bits 8v+7 down to 8v |
| ack_i | input | 1 | CPU acknowledge of a vector |
| ack_vec_i | input | 2 | Index of the vector being acknowledged |
| irq_pend_o | output | 4 | Pending bit of each vector |

## Verification
The bench sweeps every module flag bit of every vector under enable masks of all zeros, all ones and a mixed pattern. It checks the re-raise after a clear, both when another enabled flag remains and when none does. A design that ignores the remaining flags would drop the second interrupt. A design that re-raises whenever any flag remains, enabled or not, would fire a spurious interrupt. The bench also drives event and clear together, and acknowledge and set together. A design with the priority reversed would lose an event or miss the new interrupt. Finally it writes all 256 values to the CPU register, which exposes any lane swapped between a pending bit and its output.

// File: rtl/intagg_pkg.sv
package intagg_pkg;
  localparam int unsigned DATA_W = 8;
  typedef logic [DATA_W-1:0] byte_t;
endpackage

// File: rtl/intagg_modgrp.sv
// Module flag and enable registers of one vector, plus its set request.
module intagg_modgrp
  import intagg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  flag_we,
  input  logic  en_we,
  input  byte_t wdata,
  input  byte_t evt,
  output byte_t flag_q,
  output byte_t en_q,
  output logic  set_req
);
  byte_t flag_nxt;
  logic  flag_upd;
  logic  hit;
  logic  reeval;

  // Clear by writing zero; the event OR comes last, so a set beats a clear.
  always_comb begin
    flag_nxt = flag_we ? (flag_q & wdata) : flag_q;
    flag_nxt = flag_nxt | evt;
    flag_upd = flag_we | (|evt);
    hit      = |(evt & en_q);
    reeval   = flag_we & (|(flag_nxt & en_q));
    set_req  = hit | reeval;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else if (flag_upd) begin
      flag_q <= flag_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_we) begin
      en_q <= wdata;
    end
  end
endmodule

// File: rtl/intagg_cpureg.sv
// Shared CPU-level flag register: software write, then ack clear, then set.
module intagg_cpureg
  import intagg_pkg::*;
#(
  parameter int unsigned NUM_VEC = 4,
  parameter logic [DATA_W-1:0] CPU_RST = 8'h05,
  localparam int unsigned VEC_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  byte_t              wdata,
  input  logic [NUM_VEC-1:0] set_req,
  input  logic               ack,
  input  logic [VEC_W-1:0]   ack_vec,
  output byte_t              cpu_q,
  output logic [NUM_VEC-1:0] irq_o
);
  byte_t cpu_nxt;
  logic  cpu_upd;

  always_comb begin
    cpu_nxt = cpu_q;
    if (we) begin
      cpu_nxt = wdata;
    end
    for (int v = 0; v < NUM_VEC; v++) begin
      if (ack && (ack_vec == VEC_W'(v))) begin
        cpu_nxt[2*v+1] = 1'b0;
      end
      if (set_req[v]) begin
        cpu_nxt[2*v+1] = 1'b1;
      end
    end
    cpu_upd = we | ack | (|set_req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_q <= CPU_RST;
    end else if (cpu_upd) begin
      cpu_q <= cpu_nxt;
    end
  end

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_irq
    assign irq_o[v] = cpu_q[2*v+1];
  end
endmodule

// File: rtl/intagg_rdmux.sv
// Combinational read mux over the register map.
module intagg_rdmux
  import intagg_pkg::*;
#(
  parameter int unsigned NUM_VEC = 4,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic [ADDR_W-1:0]         addr,
  input  byte_t                     cpu_q,
  input  logic [NUM_VEC*DATA_W-1:0] flags,
  input  logic [NUM_VEC*DATA_W-1:0] ens,
  output byte_t                     rdata
);
  always_comb begin
    rdata = '0;
    if (addr == '0) begin
      rdata = cpu_q;
    end
    for (int v = 0; v < NUM_VEC; v++) begin
      if (addr == ADDR_W'(1 + 2*v)) begin
        rdata = flags[v*DATA_W +: DATA_W];
      end
      if (addr == ADDR_W'(2 + 2*v)) begin
        rdata = ens[v*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/intflag_agg.sv
module intflag_agg
  import intagg_pkg::*;
#(
  parameter int unsigned NUM_VEC = 4,
  parameter logic [7:0]  CPU_RST = 8'h05,
  localparam int unsigned NUM_REGS = 1 + 2*NUM_VEC,
  localparam int unsigned ADDR_W   = $clog2(NUM_REGS),
  localparam int unsigned VEC_W    = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1,
  localparam int unsigned EVT_W    = NUM_VEC * DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  input  logic [EVT_W-1:0]   evt_i,
  input  logic               ack_i,
  input  logic [VEC_W-1:0]   ack_vec_i,
  output logic [NUM_VEC-1:0] irq_pend_o
);
  logic [EVT_W-1:0]   flag_all;
  logic [EVT_W-1:0]   en_all;
  logic [NUM_VEC-1:0] set_req;
  logic               cpu_we;
  byte_t              cpu_q;

  assign cpu_we = reg_wr && (reg_addr == '0);

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    logic flag_we;
    logic en_we;
    byte_t flag_q;
    byte_t en_q;
    assign flag_we = reg_wr && (reg_addr == ADDR_W'(1 + 2*v));
    assign en_we   = reg_wr && (reg_addr == ADDR_W'(2 + 2*v));

    intagg_modgrp u_grp (
      .clk     (clk),
      .rst_n   (rst_n),
      .flag_we (flag_we),
      .en_we   (en_we),
      .wdata   (reg_wdata),
      .evt     (evt_i[v*DATA_W +: DATA_W]),
      .flag_q  (flag_q),
      .en_q    (en_q),
      .set_req (set_req[v])
    );
    assign flag_all[v*DATA_W +: DATA_W] = flag_q;
    assign en_all[v*DATA_W +: DATA_W]   = en_q;
  end

  intagg_cpureg #(
    .NUM_VEC (NUM_VEC),
    .CPU_RST (CPU_RST)
  ) u_cpu (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cpu_we),
    .wdata   (reg_wdata),
    .set_req (set_req),
    .ack     (ack_i),
    .ack_vec (ack_vec_i),
    .cpu_q   (cpu_q),
    .irq_o   (irq_pend_o)
  );

  intagg_rdmux #(
    .NUM_VEC (NUM_VEC),
    .ADDR_W  (ADDR_W)
  ) u_rd (
    .addr  (reg_addr),
    .cpu_q (cpu_q),
    .flags (flag_all),
    .ens   (en_all),
    .rdata (reg_rdata)
  );
endmodule

// File: rtl/intflag_agg_chk.sv
module intflag_agg_chk #(
  parameter int unsigned NUM_VEC = 4,
  localparam int unsigned VEC_W  = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1,
  localparam int unsigned EVT_W  = NUM_VEC * 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic [EVT_W-1:0]   evt_i,
  input logic               ack_i,
  input logic [VEC_W-1:0]   ack_vec_i,
  input logic [NUM_VEC-1:0] irq_pend_o,
  input logic [EVT_W-1:0]   flag_all,
  input logic [EVT_W-1:0]   en_all
);
  always @(posedge clk) begin
    if (!rst_n) begin
      // R1
      rst_quiet_chk: assert (irq_pend_o == '0 && flag_all == '0 && en_all == '0);
    end
  end

  // R7
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && !ack_i && evt_i == '0) |=> $stable(irq_pend_o));

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_v
    // R2
    enabled_evt_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(evt_i[v*8 +: 8] & en_all[v*8 +: 8])) |=> irq_pend_o[v]);
    // R5
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && ack_vec_i == VEC_W'(v) && !reg_wr && evt_i[v*8 +: 8] == '0)
      |=> !irq_pend_o[v]);
  end

  for (genvar b = 0; b < EVT_W; b++) begin : g_b
    // R6
    evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i[b] |=> flag_all[b]);
    // R3
    no_sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_all[b] && !evt_i[b]) |=> !flag_all[b]);
  end
endmodule

bind intflag_agg intflag_agg_chk #(.NUM_VEC(NUM_VEC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .evt_i      (evt_i),
  .ack_i      (ack_i),
  .ack_vec_i  (ack_vec_i),
  .irq_pend_o (irq_pend_o),
  .flag_all   (flag_all),
  .en_all     (en_all)
);

// File: tb/intflag_agg_tb.sv
`timescale 1ns/100ps
module intflag_agg_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [3:0]  reg_addr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic [31:0] evt_i;
  logic        ack_i;
  logic [1:0]  ack_vec_i;
  logic [3:0]  irq_pend_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] m_flag [4];
  logic [7:0] m_en   [4];
  logic [7:0] m_cpu;

  always #2 clk = ~clk;

  intflag_agg u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_i(evt_i),
    .ack_i(ack_i), .ack_vec_i(ack_vec_i), .irq_pend_o(irq_pend_o)
  );

  task automatic chk(input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // Compare pending outputs and every register against the model.
  task automatic check_all(input string tag);
    logic [7:0] d;
    logic [3:0] exp_irq;
    for (int v = 0; v < 4; v++) exp_irq[v] = m_cpu[2*v+1];
    chk(tag, "irq_pend_o", {4'h0, irq_pend_o}, {4'h0, exp_irq});
    rd(4'd0, d); chk(tag, "cpu reg", d, m_cpu);
    for (int v = 0; v < 4; v++) begin
      rd(4'(1 + 2*v), d); chk(tag, "flag reg", d, m_flag[v]);
      rd(4'(2 + 2*v), d); chk(tag, "enable reg", d, m_en[v]);
    end
  endtask

  // One cycle of stimulus; model follows R2..R9.
  task automatic step(input logic [31:0] evt, input logic wr, input logic [3:0] addr,
                      input logic [7:0] wd, input logic ack, input logic [1:0] av,
                      input string tag);
    logic [7:0] nf [4];
    logic [7:0] ne [4];
    logic [7:0] nc;
    logic       setv [4];
    @(negedge clk);
    evt_i = evt; reg_wr = wr; reg_addr = addr; reg_wdata = wd;
    ack_i = ack; ack_vec_i = av;
    for (int v = 0; v < 4; v++) begin
      logic [7:0] ev;
      ev = evt[v*8 +: 8];
      nf[v] = (wr && addr == 4'(1 + 2*v)) ? (m_flag[v] & wd) : m_flag[v];
      nf[v] = nf[v] | ev;
      ne[v] = (wr && addr == 4'(2 + 2*v)) ? wd : m_en[v];
      setv[v] = ((ev & m_en[v]) != 0) ||
                (wr && addr == 4'(1 + 2*v) && ((nf[v] & m_en[v]) != 0));
    end
    nc = (wr && addr == 4'd0) ? wd : m_cpu;
    if (ack) nc[2*av+1] = 1'b0;
    for (int v = 0; v < 4; v++) if (setv[v]) nc[2*v+1] = 1'b1;
    @(posedge clk);
    #1;
    evt_i = '0; reg_wr = 1'b0; ack_i = 1'b0; reg_wdata = '0;
    for (int v = 0; v < 4; v++) begin m_flag[v] = nf[v]; m_en[v] = ne[v]; end
    m_cpu = nc;
    check_all(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] pat;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    evt_i = '0; ack_i = 1'b0; ack_vec_i = '0;
    for (int v = 0; v < 4; v++) begin m_flag[v] = '0; m_en[v] = '0; end
    m_cpu = 8'h05;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    check_all("R1");
    // R8: unmapped addresses read zero
    for (int a = 9; a < 16; a++) begin
      rd(4'(a), d); chk("R8", "unmapped read", d, 8'h00);
    end

    for (int p = 0; p < 3; p++) begin
      for (int v = 0; v < 4; v++) begin
        pat = (p == 0) ? 8'h00 : (p == 1) ? 8'hFF : (8'h69 ^ 8'(v * 8'h11));
        // R8: enable write and readback
        step('0, 1'b1, 4'(2 + 2*v), pat, 1'b0, 2'd0, "R8");
        for (int b = 0; b < 8; b++) begin
          int b2;
          logic [3:0] fa;
          b2 = (b + 3) % 8;
          fa = 4'(1 + 2*v);
          // R2: single event, then a second one
          step(32'd1 << (v*8 + b), 1'b0, 4'd0, 8'h00, 1'b0, 2'd0, "R2");
          step(32'd1 << (v*8 + b2), 1'b0, 4'd0, 8'h00, 1'b0, 2'd0, "R2");
          // R5: acknowledge clears only this vector
          step('0, 1'b0, 4'd0, 8'h00, 1'b1, 2'(v), "R5");
          // R4: clear one flag, the other may re-raise
          step('0, 1'b1, fa, ~(8'd1 << b), 1'b0, 2'd0, "R4");
          step('0, 1'b0, 4'd0, 8'h00, 1'b1, 2'(v), "R5");
          // R4: clear the last flag, nothing remains
          step('0, 1'b1, fa, ~(8'd1 << b2), 1'b0, 2'd0, "R4");
          // R6: event and clear of the same bit together
          step(32'd1 << (v*8 + b), 1'b1, fa, ~(8'd1 << b), 1'b0, 2'd0, "R6");
          // R3: writing ones changes nothing
          step('0, 1'b1, fa, 8'hFF, 1'b0, 2'd0, "R3");
          step('0, 1'b1, fa, ~(8'd1 << b), 1'b0, 2'd0, "R3");
          // R5: acknowledge together with a new event on this vector
          step(32'd1 << (v*8 + b), 1'b0, 4'd0, 8'h00, 1'b1, 2'(v), "R5");
          step('0, 1'b1, fa, 8'h00, 1'b0, 2'd0, "R3");
          step('0, 1'b0, 4'd0, 8'h00, 1'b1, 2'(v), "R5");
        end
      end
    end

    // R7: every value of the CPU flag register
    for (int x = 0; x < 256; x++) begin
      step('0, 1'b1, 4'd0, 8'(x), 1'b0, 2'd0, "R7");
    end

    // R9: software write combined with hardware set and acknowledge
    for (int v = 0; v < 4; v++) begin
      step('0, 1'b1, 4'(2 + 2*v), 8'hFF, 1'b0, 2'd0, "R9");
      step(32'd1 << (v*8), 1'b1, 4'd0, 8'h00, 1'b0, 2'd0, "R9");
      step('0, 1'b1, 4'd0, 8'hFF, 1'b1, 2'(v), "R9");
      step(32'd1 << (v*8 + 1), 1'b1, 4'd0, 8'h00, 1'b1, 2'(v), "R9");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule